// File: doc/BRIEF.md
# Multi-Rate Search and Lock Controller

This block is the digital controller of a multi-rate serial reclocker. It runs on the reference crystal clock and uses that clock as its time base. An external divider, set by the trial rate code that this block drives, brings the VCO down to a pulse train. When the VCO runs at the selected data rate, that pulse train has a known nominal density per measurement window. The block counts these pulses over fixed windows of reference cycles. It declares lock when a window's count falls inside a tight band around the nominal count. It drops lock when the count leaves a band twice as wide.

In automatic mode the block steps through six candidate rates in a fixed cycle. The codes are 0 (143 Mb/s), 1 (177), 2 (270), 3 (360), 4 (540) and 5 (1483.5/1485). The block stays on each candidate for a set number of windows. A control input takes the 177 Mb/s candidate out of the cycle. In manual mode the programmed code is the only candidate and no stepping takes place. A flag from the phase-tracking loop forces an immediate unlock. The block registers all of its outputs: the trial code for the divider, a rate indication, a locked flag and an SD flag.

Top module: `rate_lock_ctrl`

## Requirements
- R1: While reset is held, `trial_rate` and `rate_ind` are 000 and `locked` and `sd_flag` are 0; after reset the search starts at code 000.
- R2: In automatic mode and while unlocked, `trial_rate` advances in the order 000, 001, 010, 011, 100, 101 (101 only when HD_SUPPORT is 1) and then wraps to 000. It advances after DWELL_WIN unsuccessful windows of WIN_CYC cycles each, so one step lasts exactly DWELL_WIN*WIN_CYC cycles.
- R3: With `skip_177` high in automatic mode, the step after 000 is 010, and a window that ends with `trial_rate` at 001 never declares lock; it advances at once instead.
- R4: A measurement window is WIN_CYC cycles of `vco_tick` counting and restarts whenever `trial_rate` changes or lock is forced off. While unlocked, a window whose count differs from NOM_CNT by at most NOM_CNT/100 sets `locked` at the window's closing edge.
- R5: While locked, `trial_rate` is held. Lock is dropped only when a window's count differs from NOM_CNT by more than NOM_CNT/50. After a drop, acquisition resumes at the same code.
- R6: `rate_ind` takes the value of `trial_rate` on the edge where lock is declared and otherwise keeps its value, including after lock is lost.
- R7: `pa_fault` high while locked clears `locked` on the next edge and restarts the window.
- R8: In manual mode, a valid `man_rate` that differs from `trial_rate` is copied to `trial_rate` on the next edge and clears `locked`; no stepping occurs whatever the window results.
- R9: Manual codes 110 and 111 are ignored, as is 101 when HD_SUPPORT is 0; `trial_rate` and `locked` keep their values.
- R10: `sd_flag` is 1 exactly when `locked` is 1 and `trial_rate` is not 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference crystal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_tick | input | 1 | One-cycle pulse from the divided VCO, synchronous to clk |
| auto_en | input | 1 | 1 = automatic rate search, 0 = manual rate |
| man_rate | input | 3 | Programmed rate code in manual mode |
| skip_177 | input | 1 | Removes code 001 from the automatic search |
| pa_fault | input | 1 | Phase-tracking loop reports loss; forces unlock |
| trial_rate | output | 3 | Rate code applied to the VCO divider |
| rate_ind | output | 3 | Rate code of the most recent lock |
| locked | output | 1 | Frequency lock flag |
| sd_flag | output | 1 | High when locked to an SD rate |

## Verification
The hardest state to reach from the ports is a locked loop whose count sits between the acquire band and the drop band. Holding lock there, and losing it just beyond, depends on window counts that the stimulus must set exactly. The bench drives `vco_tick` from a fractional accumulator. The accumulator is keyed on whether the current trial code matches a chosen "true" rate, so every full window holds an exact pulse count such as 102 or 103. The bench then walks lock through acquire, hold, drop and reacquire. A segment-length measurement in automatic mode with no matching rate confirms the dwell time, the wrap and the skipped step.

// File: rtl/rlc_pkg.sv
// Package: shared rate codes for the multi-rate lock controller.
// Assumes a 3-bit code space with codes 0..5 meaningful.
package rlc_pkg;
    localparam logic [2:0] RC_143 = 3'd0;
    localparam logic [2:0] RC_177 = 3'd1;
    localparam logic [2:0] RC_270 = 3'd2;
    localparam logic [2:0] RC_360 = 3'd3;
    localparam logic [2:0] RC_540 = 3'd4;
    localparam logic [2:0] RC_HD  = 3'd5;
endpackage

// File: rtl/freq_window.sv
// freq_window: counts divided-VCO pulses over a window of WIN_CYC reference
// cycles. win_end marks the window's last cycle; meas then holds the full
// count including that cycle's pulse. restart discards the running window.
// Assumes vco_tick is already synchronous to clk.
module freq_window #(
    parameter int WIN_CYC = 200,
    localparam int CW = $clog2(WIN_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    output logic          win_end,
    output logic [CW-1:0] meas
);
    logic [CW-1:0] wcnt;
    logic [CW-1:0] tcnt;

    assign win_end = (wcnt == CW'(WIN_CYC - 1));
    assign meas    = tcnt + CW'(tick);

    // Advance the cycle and pulse counters; clear both at window end or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || win_end) begin
            wcnt <= '0;
            tcnt <= '0;
        end else begin
            wcnt <= wcnt + 1'b1;
            tcnt <= meas;
        end
    end

    AST_TICKS_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt <= wcnt);  // R4
endmodule

// File: rtl/window_judge.sv
// window_judge: compares a window count with the nominal count and reports
// whether it lies in the acquire band (1 %) and in the hold band (2 %).
// Purely combinational; assumes NOM_CNT < 2**CW.
module window_judge #(
    parameter int NOM_CNT = 100,
    parameter int CW      = 8
) (
    input  logic [CW-1:0] meas,
    output logic          in_acq,
    output logic          in_hold
);
    localparam logic [CW-1:0] NOM      = CW'(NOM_CNT);
    localparam logic [CW-1:0] ACQ_TOL  = CW'(NOM_CNT / 100);
    localparam logic [CW-1:0] DROP_TOL = CW'(NOM_CNT / 50);

    logic [CW-1:0] err;

    // Absolute distance between the measured and nominal counts.
    always_comb begin
        err     = (meas >= NOM) ? (meas - NOM) : (NOM - meas);
        in_acq  = (err <= ACQ_TOL);
        in_hold = (err <= DROP_TOL);
    end
endmodule

// File: rtl/rate_stepper.sv
// rate_stepper: gives the next candidate of the automatic search.
// The order is fixed; code 001 can be skipped, and the HD code exists only
// when HD_SUPPORT is set. Combinational.
module rate_stepper
    import rlc_pkg::*;
#(
    parameter int HD_SUPPORT = 1
) (
    input  logic [2:0] cur,
    input  logic       skip_177,
    output logic [2:0] nxt
);
    logic [2:0] last_code;

    generate
        if (HD_SUPPORT != 0) begin : g_hd
            assign last_code = RC_HD;
        end else begin : g_sd
            assign last_code = RC_540;
        end
    endgenerate

    // Pick the successor of the current candidate.
    always_comb begin
        if (cur >= last_code)
            nxt = RC_143;
        else if (cur == RC_143 && skip_177)
            nxt = RC_270;
        else
            nxt = cur + 3'd1;
    end
endmodule

// File: rtl/rate_lock_ctrl.sv
// rate_lock_ctrl: search-and-lock controller of a multi-rate reclocker PLL.
// Clocked by the reference crystal. Drives the divider code, tracks lock with
// a 1 % acquire band and a 2 % drop band, and registers every output.
// Assumes vco_tick and all control inputs are synchronous to clk.
module rate_lock_ctrl
    import rlc_pkg::*;
#(
    parameter int WIN_CYC    = 200,
    parameter int NOM_CNT    = 100,
    parameter int DWELL_WIN  = 3,
    parameter int HD_SUPPORT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vco_tick,
    input  logic       auto_en,
    input  logic [2:0] man_rate,
    input  logic       skip_177,
    input  logic       pa_fault,
    output logic [2:0] trial_rate,
    output logic [2:0] rate_ind,
    output logic       locked,
    output logic       sd_flag
);
    localparam int CW  = $clog2(WIN_CYC + 1);
    localparam int DWW = $clog2(DWELL_WIN + 1);
    localparam logic [DWW-1:0] DWELL_LAST = DWW'(DWELL_WIN - 1);

    logic          win_end;
    logic [CW-1:0] meas;
    logic          in_acq, in_hold;
    logic [2:0]    step_rate;
    logic [DWW-1:0] dwell;

    logic          man_ok, man_chg, pa_drop, restart, blocked;
    logic [2:0]    try_n, ind_n;
    logic          lock_n;
    logic [DWW-1:0] dwell_n;

    freq_window #(.WIN_CYC(WIN_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(vco_tick),
        .win_end(win_end), .meas(meas)
    );

    window_judge #(.NOM_CNT(NOM_CNT), .CW(CW)) u_judge (
        .meas(meas), .in_acq(in_acq), .in_hold(in_hold)
    );

    rate_stepper #(.HD_SUPPORT(HD_SUPPORT)) u_step (
        .cur(trial_rate), .skip_177(skip_177), .nxt(step_rate)
    );

    // Classify this cycle's events that override window evaluation.
    always_comb begin
        man_ok  = (man_rate <= RC_540) || ((HD_SUPPORT != 0) && (man_rate == RC_HD));
        man_chg = !auto_en && man_ok && (man_rate != trial_rate);
        pa_drop = locked && pa_fault;
        restart = man_chg || pa_drop;
        blocked = auto_en && skip_177 && (trial_rate == RC_177);
    end

    // Next-state decision for candidate, lock, dwell and indication.
    always_comb begin
        try_n   = trial_rate;
        lock_n  = locked;
        dwell_n = dwell;
        ind_n   = rate_ind;
        if (man_chg) begin
            try_n   = man_rate;
            lock_n  = 1'b0;
            dwell_n = '0;
        end else if (pa_drop) begin
            lock_n  = 1'b0;
            dwell_n = '0;
        end else if (win_end) begin
            if (locked) begin
                if (!in_hold) begin
                    lock_n  = 1'b0;
                    dwell_n = '0;
                end
            end else if (!blocked && in_acq) begin
                lock_n  = 1'b1;
                ind_n   = trial_rate;
                dwell_n = '0;
            end else if (auto_en) begin
                if (blocked || dwell == DWELL_LAST) begin
                    try_n   = step_rate;
                    dwell_n = '0;
                end else begin
                    dwell_n = dwell + 1'b1;
                end
            end else begin
                dwell_n = '0;
            end
        end
    end

    // Register the controller state and every output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_rate <= RC_143;
            rate_ind   <= RC_143;
            locked     <= 1'b0;
            sd_flag    <= 1'b0;
            dwell      <= '0;
        end else begin
            trial_rate <= try_n;
            rate_ind   <= ind_n;
            locked     <= lock_n;
            sd_flag    <= lock_n && (try_n != RC_HD);
            dwell      <= dwell_n;
        end
    end

    AST_TRIAL_HELD_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (!locked || $stable(trial_rate)));  // R5
    AST_SD_ONLY_WHEN_SD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sd_flag |-> (locked && trial_rate != RC_HD));  // R10
    AST_SD_SET_ON_SD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && trial_rate != RC_HD) |-> sd_flag);  // R10
    AST_IND_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (rate_ind == trial_rate));  // R6
    AST_IND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(locked) |-> $stable(rate_ind));  // R6
    AST_NO_177_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> !($past(auto_en) && $past(skip_177) && $past(trial_rate) == RC_177));  // R3
    AST_PA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && pa_fault) |=> !locked);  // R7
    AST_TRIAL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        trial_rate <= ((HD_SUPPORT != 0) ? RC_HD : RC_540));  // R9
endmodule

// File: tb/tb_rate_lock_ctrl.sv
module tb_rate_lock_ctrl;
    localparam int WIN  = 200;
    localparam int NOM  = 100;
    localparam int DW   = 3;
    localparam int ACQ  = NOM / 100;
    localparam int DROP = NOM / 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vco_tick = 1'b0, auto_en = 1'b0, skip_177 = 1'b0, pa_fault = 1'b0;
    logic [2:0] man_rate = 3'd0;
    logic [2:0] trial_rate, rate_ind, sd_trial, sd_ind;
    logic locked, sd_flag, sd_locked, sd_sdf;

    always #5 clk = ~clk;

    rate_lock_ctrl #(.WIN_CYC(WIN), .NOM_CNT(NOM), .DWELL_WIN(DW), .HD_SUPPORT(1)) dut (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .auto_en(auto_en),
        .man_rate(man_rate), .skip_177(skip_177), .pa_fault(pa_fault),
        .trial_rate(trial_rate), .rate_ind(rate_ind), .locked(locked), .sd_flag(sd_flag));

    rate_lock_ctrl #(.WIN_CYC(WIN), .NOM_CNT(NOM), .DWELL_WIN(DW), .HD_SUPPORT(0)) dut_sd (
        .clk(clk), .rst_n(rst_n), .vco_tick(1'b0), .auto_en(1'b0),
        .man_rate(man_rate), .skip_177(1'b0), .pa_fault(1'b0),
        .trial_rate(sd_trial), .rate_ind(sd_ind), .locked(sd_locked), .sd_flag(sd_sdf));

    // scenario controls, changed just after posedge
    int s_src = 7, s_match = 100, s_off = 60, s_auto = 0, s_code = 0, s_skip = 0, s_pa = 0;
    // reference model state
    int m_try = 0, m_ind = 0, m_lock = 0, m_sd = 0, m_dw = 0, m_w = 0, m_t = 0, acc = 0;
    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nxt_rate(input int r, input int skip);
        if (r >= 5) return 0;
        if (r == 0 && skip != 0) return 2;
        return r + 1;
    endfunction

    // compare with the model, then drive inputs and advance the model
    always @(negedge clk) begin
        int dens, t, meas, err, valid, blk;
        if (rst_n && !done) begin
            chk(trial_rate == 3'(m_try), "R2/R8 model trial_rate", trial_rate, m_try);
            chk(locked == m_lock[0], "R4/R5 model locked", locked, m_lock);
            chk(rate_ind == 3'(m_ind), "R6 model rate_ind", rate_ind, m_ind);
            chk(sd_flag == m_sd[0], "R10 model sd_flag", sd_flag, m_sd);
        end
        dens = (m_try == s_src) ? s_match : s_off;
        acc += dens;
        t = 0;
        if (acc >= WIN) begin t = 1; acc -= WIN; end
        vco_tick = t[0]; auto_en = s_auto[0]; man_rate = 3'(s_code);
        skip_177 = s_skip[0]; pa_fault = s_pa[0];
        if (!rst_n) begin
            m_try = 0; m_ind = 0; m_lock = 0; m_sd = 0; m_dw = 0; m_w = 0; m_t = 0;
        end else begin
            valid = (s_code <= 5) ? 1 : 0;
            if (s_auto == 0 && valid != 0 && s_code != m_try) begin
                m_try = s_code; m_lock = 0; m_dw = 0; m_w = 0; m_t = 0;
            end else if (m_lock != 0 && s_pa != 0) begin
                m_lock = 0; m_dw = 0; m_w = 0; m_t = 0;
            end else if (m_w == WIN - 1) begin
                meas = m_t + t; m_w = 0; m_t = 0;
                err = (meas > NOM) ? meas - NOM : NOM - meas;
                blk = (s_auto != 0 && s_skip != 0 && m_try == 1) ? 1 : 0;
                if (m_lock != 0) begin
                    if (err > DROP) begin m_lock = 0; m_dw = 0; end
                end else if (blk == 0 && err <= ACQ) begin
                    m_lock = 1; m_ind = m_try; m_dw = 0;
                end else if (s_auto != 0) begin
                    if (blk != 0 || m_dw == DW - 1) begin m_try = nxt_rate(m_try, s_skip); m_dw = 0; end
                    else m_dw++;
                end else m_dw = 0;
            end else begin
                m_w++; m_t += t;
            end
            m_sd = (m_lock != 0 && m_try != 5) ? 1 : 0;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int prev, seg, nseg, seen1, wrap, skip02, seglen3;
        wait_cyc(5);
        // R1 reset state
        chk(trial_rate == 3'd0, "R1 trial_rate in reset", trial_rate, 0);
        chk(rate_ind == 3'd0, "R1 rate_ind in reset", rate_ind, 0);
        chk(locked == 1'b0, "R1 locked in reset", locked, 0);
        chk(sd_flag == 1'b0, "R1 sd_flag in reset", sd_flag, 0);
        rst_n = 1'b1;
        // R2/R4: automatic search finds 270 Mb/s
        s_auto = 1; s_src = 2; s_match = 100;
        wait_cyc(2000);
        chk(locked == 1'b1, "R4 lock at matching rate", locked, 1);
        chk(trial_rate == 3'd2, "R2 search reached code 010", trial_rate, 2);
        chk(rate_ind == 3'd2, "R6 indication after lock", rate_ind, 2);
        chk(sd_flag == 1'b1, "R10 sd_flag on SD lock", sd_flag, 1);
        // R5: 2 % band holds lock, beyond it drops
        s_match = 102; wait_cyc(1200);
        chk(locked == 1'b1, "R5 hold inside drop band", locked, 1);
        s_match = 103; wait_cyc(800);
        chk(locked == 1'b0, "R5 drop outside band", locked, 0);
        chk(rate_ind == 3'd2, "R6 indication held after loss", rate_ind, 2);
        s_match = 100; wait_cyc(4500);
        chk(locked == 1'b1 && trial_rate == 3'd2, "R5 reacquire", locked, 1);
        // R7: phase loop fault
        s_pa = 1; wait_cyc(1); s_pa = 0;
        chk(locked == 1'b0, "R7 unlock after fault", locked, 0);
        wait_cyc(450);
        chk(locked == 1'b1, "R7 relock after fault", locked, 1);
        // R8: manual mode
        s_auto = 0; s_code = 4; s_src = 4; wait_cyc(1);
        chk(trial_rate == 3'd4, "R8 manual code applied", trial_rate, 4);
        chk(locked == 1'b0, "R8 manual change clears lock", locked, 0);
        chk(sd_trial == 3'd4, "R8 SD-only build follows code", sd_trial, 4);
        wait_cyc(500);
        chk(locked == 1'b1 && sd_flag == 1'b1, "R10 manual SD lock", sd_flag, 1);
        chk(rate_ind == 3'd4, "R6 manual indication", rate_ind, 4);
        s_code = 5; s_src = 5; wait_cyc(1);
        chk(sd_trial == 3'd4, "R9 SD-only build ignores 101", sd_trial, 4);
        wait_cyc(500);
        chk(locked == 1'b1, "R4 lock at HD", locked, 1);
        chk(sd_flag == 1'b0, "R10 sd_flag low at HD", sd_flag, 0);
        s_code = 6; wait_cyc(3);
        chk(trial_rate == 3'd5 && locked == 1'b1, "R9 code 110 ignored", trial_rate, 5);
        s_code = 3; s_src = 0; wait_cyc(2000);
        chk(trial_rate == 3'd3, "R8 no stepping in manual", trial_rate, 3);
        chk(locked == 1'b0, "R8 no lock on mismatch", locked, 0);
        // R2/R3: automatic with skip, no matching rate
        s_skip = 1; s_src = 7; s_auto = 1;
        prev = 3; seg = 0; nseg = 0; seen1 = 0; wrap = 0; skip02 = 0; seglen3 = 0;
        for (int i = 0; i < 9000; i++) begin
            wait_cyc(1);
            seg++;
            if (trial_rate == 3'd1) seen1++;
            if (trial_rate != 3'(prev)) begin
                nseg++;
                if (nseg == 3) seglen3 = seg;
                if (prev == 5 && trial_rate == 3'd0) wrap = 1;
                if (prev == 0 && trial_rate == 3'd2) skip02 = 1;
                prev = trial_rate; seg = 0;
            end
        end
        chk(seen1 == 0, "R3 code 001 never tried", seen1, 0);
        chk(skip02 == 1, "R3 step 000 to 010", skip02, 1);
        chk(wrap == 1, "R2 wrap 101 to 000", wrap, 1);
        chk(seglen3 == DW * WIN, "R2 dwell length", seglen3, DW * WIN);
        s_src = 1; wait_cyc(4000);
        chk(locked == 1'b0, "R3 no lock at 177 with skip", locked, 0);
        finish_run();
    end
endmodule